// File: doc/BRIEF.md
# Serial DAC Command Word Receiver

This block sits behind the serial port of a multi-channel converter. It takes in a command word framed by an active-low chip-select, with data sampled on each rising edge of the serial clock. When chip-select rises, the block checks how many clock edges the frame held. A 24-edge frame is decoded directly. A 32-edge frame is decoded from its final 24 bits, and its eight leading bits are dropped. Any other length is thrown away.

A decoded word splits into a 4-bit command, a 4-bit channel address and a 16-bit data field, all sent most significant bit first. The command drives one single-cycle strobe: write code, update, write span to one channel, or write span to all channels. The address, data and span code outputs are held stable for the register banks that follow.

A serial output returns every received bit exactly 32 shift edges later. This lets a host read a 32-bit frame back during the next frame, or pass words through a chain of devices.

The serial inputs are sampled on the system clock. Each serial clock level must therefore last at least one system clock cycle.

Top module: `sdac_cmd_rx`

## Requirements
- R1: While reset is asserted and just after it is released, all strobes are 0, `sdo` is 0, and `cmd_o`, `addr_o`, `data_o` and `span_o` are 0.
- R2: A bit is shifted in only on a rising `sck` while `cs_n` is low. `sck` activity while `cs_n` is high changes neither the echo stream nor the next decode.
- R3: When `cs_n` rises after exactly 24 shifts, the fields are captured from the received bits in order: bits 1-4 go to `cmd_o`, bits 5-8 to `addr_o`, and bits 9-24 to `data_o`. These outputs are valid one clock after the system-clock edge that sees `cs_n` high.
- R4: After exactly 32 shifts, the first 8 bits are ignored and the last 24 bits are decoded as in R3.
- R5: A frame of any other length raises no strobe and leaves `cmd_o`, `addr_o`, `data_o` and `span_o` unchanged.
- R6: Command 0000 raises `wr_code_o` for exactly one clock, in the same cycle the fields update.
- R7: Command 0110 raises `wr_span_o` for one clock. `span_o` takes the last 3 data bits (`data[2:0]`), and the other 13 data bits do not affect it.
- R8: Command 1110 raises `wr_span_all_o` for one clock and loads `span_o` as in R7.
- R9: Command 0001 raises `update_o` for one clock.
- R10: After every shift, `sdo` equals the bit that was shifted in 32 shifts earlier, or 0 if fewer than 32 shifts have happened since reset.
- R11: Any other command updates the fields but raises no strobe, and `span_o` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, sampled by `clk` |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, delayed by 32 shifts |
| cmd_o | output | 4 | Command of the last valid frame |
| addr_o | output | 4 | Channel address of the last valid frame |
| data_o | output | 16 | Data field of the last valid frame |
| span_o | output | 3 | Span code of the last span write |
| wr_code_o | output | 1 | Write-code strobe |
| update_o | output | 1 | Update strobe |
| wr_span_o | output | 1 | Single-channel span strobe |
| wr_span_all_o | output | 1 | All-channel span strobe |

## Verification
The bench sends 32-bit frames that begin with eight ones of filler. A decoder that reads the first 24 bits instead of the last 24 would then report a command of 1111 and fire no strobe. Frames of 23, 25 and 33 bits are sent to catch a length check that is off by one, which would produce a spurious strobe or corrupt the held fields. Serial clock edges are also sent while chip-select is high; a design that shifted on them would move the echo stream out of line, and the bench compares that stream on every clock. Span writes carry non-zero don't-care bits, so using the wrong three bits of the data field shows up as a wrong `span_o`.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;

    localparam int CMD_W  = 4;
    localparam int ADDR_W = 4;
    localparam int SPAN_W = 3;

    typedef enum logic [CMD_W-1:0] {
        OP_WR_CODE     = 4'b0000,
        OP_UPDATE      = 4'b0001,
        OP_WR_SPAN     = 4'b0110,
        OP_WR_SPAN_ALL = 4'b1110
    } sdac_op_e;

    typedef struct packed {
        logic wr_code;
        logic update;
        logic wr_span;
        logic wr_span_all;
    } sdac_strb_t;

endpackage

// File: rtl/sdac_rx_shift.sv
module sdac_rx_shift #(
    parameter int FRAME_W = 32,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_i,
    input  logic               cs_n_i,
    input  logic               sdi_i,
    output logic [FRAME_W-1:0] shreg_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               frame_end_o,
    output logic               sdo_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic               sck;
        logic               cs_n;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      shift_en;
    logic      cs_fall;

    always_comb begin
        st_d        = st_q;
        st_d.sck    = sck_i;
        st_d.cs_n   = cs_n_i;
        shift_en    = !cs_n_i && sck_i && !st_q.sck;
        cs_fall     = !cs_n_i && st_q.cs_n;
        frame_end_o = cs_n_i && !st_q.cs_n;
        if (cs_fall || frame_end_o) begin
            st_d.cnt = '0;
        end
        if (shift_en) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdi_i};
            if (st_d.cnt != CNT_MAX) begin
                st_d.cnt = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign shreg_o = st_q.shreg;
    assign cnt_o   = st_q.cnt;
    assign sdo_o   = st_q.shreg[FRAME_W-1];

    // R2: nothing is shifted while the frame select is high
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> $stable(shreg_o));

    // R10: each shift moves the next older bit onto the serial output
    a_r10_echo_step: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sdo_o == $past(st_q.shreg[FRAME_W-2])));

endmodule

// File: rtl/sdac_rx_decode.sv
module sdac_rx_decode
    import sdac_rx_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int WORD_W  = 24,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [FRAME_W-1:0] shreg_i,
    output logic [CMD_W-1:0]   cmd_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [WORD_W-CMD_W-ADDR_W-1:0] data_o,
    output logic [SPAN_W-1:0]  span_o,
    output sdac_strb_t         strb_o
);

    localparam int DATA_W = WORD_W - CMD_W - ADDR_W;
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SPAN_W-1:0] span;
        sdac_strb_t        strb;
    } dec_st_t;

    dec_st_t           st_d, st_q;
    logic [WORD_W-1:0] word;
    logic              len_ok;
    logic [CMD_W-1:0]  op;

    always_comb begin
        st_d      = st_q;
        st_d.strb = '0;
        word      = shreg_i[WORD_W-1:0];
        op        = word[WORD_W-1 -: CMD_W];
        len_ok    = (cnt_i == LEN_SHORT) || (cnt_i == LEN_LONG);
        if (frame_end_i && len_ok) begin
            st_d.cmd  = op;
            st_d.addr = word[DATA_W +: ADDR_W];
            st_d.data = word[DATA_W-1:0];
            case (op)
                OP_WR_CODE: st_d.strb.wr_code = 1'b1;
                OP_UPDATE:  st_d.strb.update  = 1'b1;
                OP_WR_SPAN: begin
                    st_d.strb.wr_span = 1'b1;
                    st_d.span         = word[SPAN_W-1:0];
                end
                OP_WR_SPAN_ALL: begin
                    st_d.strb.wr_span_all = 1'b1;
                    st_d.span             = word[SPAN_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = st_q.cmd;
    assign addr_o = st_q.addr;
    assign data_o = st_q.data;
    assign span_o = st_q.span;
    assign strb_o = st_q.strb;

    // R5: a strobe only follows a frame of 24 or 32 shifts
    a_r5_len_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (|strb_o) |-> ($past(cnt_i) == LEN_SHORT || $past(cnt_i) == LEN_LONG));

    // R6: strobes last one clock
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|strb_o) |=> !(|strb_o));

    // R11: at most one strobe per frame
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb_o));

    // R7: span output moves only with a span strobe
    a_r7_span_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb_o.wr_span || strb_o.wr_span_all) |-> $stable(span_o));

endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
    import sdac_rx_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int WORD_W  = 24,
    parameter int CNT_W   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        sdi,
    output logic        sdo,
    output logic [3:0]  cmd_o,
    output logic [3:0]  addr_o,
    output logic [15:0] data_o,
    output logic [2:0]  span_o,
    output logic        wr_code_o,
    output logic        update_o,
    output logic        wr_span_o,
    output logic        wr_span_all_o
);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               frame_end;
    sdac_strb_t         strb;

    sdac_rx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck),
        .cs_n_i      (cs_n),
        .sdi_i       (sdi),
        .shreg_o     (shreg),
        .cnt_o       (cnt),
        .frame_end_o (frame_end),
        .sdo_o       (sdo)
    );

    sdac_rx_decode #(.FRAME_W(FRAME_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end_i (frame_end),
        .cnt_i       (cnt),
        .shreg_i     (shreg),
        .cmd_o       (cmd_o),
        .addr_o      (addr_o),
        .data_o      (data_o),
        .span_o      (span_o),
        .strb_o      (strb)
    );

    assign wr_code_o     = strb.wr_code;
    assign update_o      = strb.update;
    assign wr_span_o     = strb.wr_span;
    assign wr_span_all_o = strb.wr_span_all;

endmodule

// File: tb/sdac_cmd_rx_test.sv
`timescale 1ns/1ps
module sdac_cmd_rx_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo;
    logic [3:0] cmd_o, addr_o;
    logic [15:0] data_o;
    logic [2:0] span_o;
    logic wr_code_o, update_o, wr_span_o, wr_span_all_o;

    always #2.5 clk = ~clk;

    sdac_cmd_rx uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .cmd_o(cmd_o), .addr_o(addr_o), .data_o(data_o), .span_o(span_o),
        .wr_code_o(wr_code_o), .update_o(update_o), .wr_span_o(wr_span_o),
        .wr_span_all_o(wr_span_all_o)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    bit hist[$];
    logic       e_sdo = 0;
    logic [3:0] e_cmd = 0, e_addr = 0;
    logic [15:0] e_data = 0;
    logic [2:0] e_span = 0;
    logic e_wc = 0, e_up = 0, e_ws = 0, e_wsa = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk("R10 sdo", 32'(sdo), 32'(e_sdo));
        chk("R3 cmd", 32'(cmd_o), 32'(e_cmd));
        chk("R3 addr", 32'(addr_o), 32'(e_addr));
        chk("R3 data", 32'(data_o), 32'(e_data));
        chk("R7 span", 32'(span_o), 32'(e_span));
        chk("R6 wr_code", 32'(wr_code_o), 32'(e_wc));
        chk("R9 update", 32'(update_o), 32'(e_up));
        chk("R7 wr_span", 32'(wr_span_o), 32'(e_ws));
        chk("R8 wr_span_all", 32'(wr_span_all_o), 32'(e_wsa));
        e_wc = 0; e_up = 0; e_ws = 0; e_wsa = 0;
    endtask

    task automatic shift_bit(logic b);
        sdi = b; sck = 1'b0;
        step();
        sck = 1'b1;
        hist.push_back(b);
        e_sdo = (hist.size() >= 32) ? hist[hist.size()-32] : 1'b0;
        step();
    endtask

    task automatic send(logic [39:0] val, int n);
        logic [23:0] w;
        cs_n = 1'b0;
        step();
        for (int i = 0; i < n; i++) shift_bit(val[n-1-i]);
        sck = 1'b0;
        step();
        cs_n = 1'b1;
        if (n == 24 || n == 32) begin
            w = val[23:0];
            e_cmd = w[23:20]; e_addr = w[19:16]; e_data = w[15:0];
            case (w[23:20])
                4'b0000: e_wc = 1;
                4'b0001: e_up = 1;
                4'b0110: begin e_ws = 1; e_span = w[2:0]; end
                4'b1110: begin e_wsa = 1; e_span = w[2:0]; end
                default: ;
            endcase
        end
        step();
        step();
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset values
        step(); step();
        rst_n = 1'b1;
        step();
        // R6 24-bit write code
        send({16'h0, 4'b0000, 4'h5, 16'hABCD}, 24);
        // R4 R7 32-bit span write, filler ones, don't-care bits set
        send({8'h0, 8'hFF, 4'b0110, 4'h3, 16'hA5A5}, 32);
        // R8 span all
        send({8'h0, 8'hFF, 4'b1110, 4'h9, 16'hFFFA}, 32);
        // R9 update, 24 bits
        send({16'h0, 4'b0001, 4'hF, 16'h0000}, 24);
        // R5 bad lengths
        send({16'h0, 8'hC1, 4'h2, 16'h1234} >> 1, 23);
        send({15'h0, 25'h1_6123_45}, 25);
        send({7'h0, 33'h1_FF00_0000}, 33);
        // R2 sck activity with cs high
        for (int i = 0; i < 4; i++) begin
            sck = 1'b1; sdi = 1'b1; step();
            sck = 1'b0; sdi = 1'b0; step();
        end
        // R11 unknown command, then echo checks via back-to-back long frames (R10)
        send({8'h0, 8'h3C, 4'b0101, 4'h7, 16'h5A5A}, 32);
        send({8'h0, 8'hFF, 4'b0000, 4'h1, 16'h8001}, 32);
        send({8'h0, 8'h00, 4'b0110, 4'h2, 16'hFFF8}, 32);
        send({16'h0, 4'b1110, 4'h0, 16'h0007}, 24);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule